// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers a fixed set of interrupt request lines. It picks the most urgent one that is allowed to interrupt and presents it to a processor as a request line, a vector code and a priority level. Each source has a 4-bit priority field, held in 16-bit priority registers. Each source also has one bit in every mask register. A source takes part in arbitration only when it is pending, all of its mask bits are set, and its priority field is nonzero. Internally the arbitration value is 5 bits wide. It is reduced to a 4-bit level before it is compared with the processor's current level. A request goes out only when that level is strictly higher than the current level.

Software programs the controller through a simple register port. A single write strobe commits on the next clock, and a separate read address gives combinational read data. A control bit chooses between edge capture and level following for the request lines. The processor side has three parts:

- a 4-bit current level input;
- registered request, vector and level outputs;
- an acknowledge input that retires the presented source.

Once a source is presented, it stays presented until it is acknowledged or stops being eligible. A more urgent arrival does not pre-empt it in the meantime.

Top module: `vec_intc`

## Requirements
- R1: After reset the control register reads 0, the priority registers read their reset parameters (default 0xDA74 and 0x0000), the mask registers read theirs (default 0xF0 and 0xFF), and irq_req is low.
- R2: Priority register at address 1+r holds the fields of sources 4r..4r+3. Source 4r uses bits 15:12, and each later source uses the next lower nibble.
- R3: Mask register at address 3+m holds one bit per source, and source i uses bit 7-i. A source is eligible only if it is pending, its bit is set in both mask registers, and its priority field is nonzero.
- R4: With control bit 0 clear (edge mode), a 0-to-1 change seen on irq_in[i] between two clocks sets source i pending. The source stays pending until it is acknowledged.
- R5: With control bit 0 set (level mode), the pending state of each source equals irq_in sampled at the last clock, except for an acknowledged source, which is cleared for that clock.
- R6: Among eligible sources the highest priority field wins. On equal fields the lower source index wins.
- R7: A grant is made only when the winner's level is strictly greater than cpu_level. The level is the 5-bit value {field,0} shifted right by one.
- R8: While irq_req is high, irq_vec equals 0x200 + 0x20 * source index and irq_level equals the granted level. While irq_req is low, both outputs are 0.
- R9: An edge on irq_in before clock k sets pending at clock k, and irq_req can rise no earlier than clock k+1.
- R10: irq_ack sampled with irq_req high clears that source's pending state and drops irq_req at the next clock. irq_ack with irq_req low has no effect.
- R11: While irq_req is high and not acknowledged, the vector and level hold as long as the presented source remains eligible and above cpu_level, even if a higher-priority source becomes pending.
- R12: A write takes effect at the next clock. Reads return the stored value, with the control register zero-extended from bit 0. Addresses 5 to 7 read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Write address |
| reg_wdata | input | 16 | Write data |
| reg_raddr | input | 3 | Read address |
| reg_rdata | output | 16 | Combinational read data |
| irq_in | input | 8 | Request lines, one per source |
| cpu_level | input | 4 | Processor's current interrupt level |
| irq_ack | input | 1 | Acknowledge of the presented source |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vec | output | 12 | Vector code of the presented source |
| irq_level | output | 4 | Reduced level of the presented source |

## Verification
The hardest case to reach is a grant being held while something more urgent becomes pending. It needs a low-priority source presented and left unacknowledged for several cycles while a higher one arrives. The stimulus also has to tell a hold apart from a re-arbitration that happens to pick the same source. The directed sequence presents source 3, raises source 0 and withholds the acknowledge. It then drops the mask bit of the held source so that the hold must give way. A long random phase then mixes register writes, mode changes, level changes and acknowledges, and a behavioural model is compared on every cycle.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;

    // Width of a priority field and of the processor level.
    localparam int LVL_W = 4;
    // Width of the internal arbitration value.
    localparam int ARB_W = LVL_W + 1;

    // Promote a register field into the arbitration domain.
    function automatic logic [ARB_W-1:0] widen_prio(input logic [LVL_W-1:0] fld);
        return {fld, 1'b0};
    endfunction

    // Reduce an arbitration value to the level the processor compares.
    function automatic logic [LVL_W-1:0] to_level(input logic [ARB_W-1:0] arb);
        return LVL_W'(arb >> 1);
    endfunction

endpackage

// File: rtl/vec_intc_regs.sv
module vec_intc_regs
    import vec_intc_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3,
    parameter int N_MASK = 2,
    parameter logic [N_SRC*LVL_W-1:0] PRI_RST  = '0,
    parameter logic [N_MASK*N_SRC-1:0] MASK_RST = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    lvl_mode,
    output logic [N_SRC*LVL_W-1:0]  prio_flat,
    output logic [N_SRC-1:0]        mask_ok
);

    localparam int PTOT      = N_SRC * LVL_W;
    localparam int N_PRI     = PTOT / DATA_W;
    localparam int MTOT      = N_MASK * N_SRC;
    localparam int MASK_BASE = 1 + N_PRI;

    typedef struct packed {
        logic            lvl_mode;
        logic [PTOT-1:0] pri;
        logic [MTOT-1:0] mask;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(0)) begin
                r_d.lvl_mode = wr_data[0];
            end
            for (int r = 0; r < N_PRI; r++) begin
                if (wr_addr == ADDR_W'(1 + r)) begin
                    r_d.pri[PTOT-1-r*DATA_W -: DATA_W] = wr_data;
                end
            end
            for (int m = 0; m < N_MASK; m++) begin
                if (wr_addr == ADDR_W'(MASK_BASE + m)) begin
                    r_d.mask[MTOT-1-m*N_SRC -: N_SRC] = wr_data[N_SRC-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{lvl_mode: 1'b0, pri: PRI_RST, mask: MASK_RST};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(0)) begin
            rd_data[0] = r_q.lvl_mode;
        end
        for (int r = 0; r < N_PRI; r++) begin
            if (rd_addr == ADDR_W'(1 + r)) begin
                rd_data = r_q.pri[PTOT-1-r*DATA_W -: DATA_W];
            end
        end
        for (int m = 0; m < N_MASK; m++) begin
            if (rd_addr == ADDR_W'(MASK_BASE + m)) begin
                rd_data[N_SRC-1:0] = r_q.mask[MTOT-1-m*N_SRC -: N_SRC];
            end
        end
    end

    assign lvl_mode  = r_q.lvl_mode;
    assign prio_flat = r_q.pri;

    // Source i owns bit N_SRC-1-i of every mask register.
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        always_comb begin
            mask_ok[i] = 1'b1;
            for (int m = 0; m < N_MASK; m++) begin
                mask_ok[i] = mask_ok[i] & r_q.mask[(N_MASK-1-m)*N_SRC + (N_SRC-1-i)];
            end
        end
    end

endmodule

// File: rtl/vec_intc_pending.sv
module vec_intc_pending #(
    parameter int N_SRC = 8,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_in,
    input  logic             lvl_mode,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [N_SRC-1:0] pend
);

    typedef struct packed {
        logic [N_SRC-1:0] prev;
        logic [N_SRC-1:0] pend;
    } pst_t;

    pst_t s_q, s_d;
    logic [N_SRC-1:0] clr_vec;
    logic [N_SRC-1:0] rise;

    always_comb begin
        clr_vec = clr_en ? (N_SRC'(1) << clr_idx) : '0;
        rise    = irq_in & ~s_q.prev;
        s_d.prev = irq_in;
        if (lvl_mode) begin
            s_d.pend = irq_in & ~clr_vec;
        end else begin
            s_d.pend = (s_q.pend | rise) & ~clr_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend = s_q.pend;

endmodule

// File: rtl/vec_intc_arb.sv
module vec_intc_arb
    import vec_intc_pkg::*;
#(
    parameter int N_SRC = 8,
    localparam int IDX_W = $clog2(N_SRC),
    localparam int PTOT  = N_SRC * LVL_W
) (
    input  logic [N_SRC-1:0] pend,
    input  logic [PTOT-1:0]  prio_flat,
    input  logic [N_SRC-1:0] mask_ok,
    output logic [N_SRC-1:0] elig,
    output logic             found,
    output logic [IDX_W-1:0] win_idx,
    output logic [ARB_W-1:0] win_arb
);

    for (genvar i = 0; i < N_SRC; i++) begin : g_elig
        assign elig[i] = pend[i] & mask_ok[i] & (prio_flat[PTOT-1-i*LVL_W -: LVL_W] != '0);
    end

    // Ascending scan with strict compare: lowest index keeps ties.
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_arb = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (elig[i] && (!found ||
                widen_prio(prio_flat[PTOT-1-i*LVL_W -: LVL_W]) > win_arb)) begin
                found   = 1'b1;
                win_idx = IDX_W'(i);
                win_arb = widen_prio(prio_flat[PTOT-1-i*LVL_W -: LVL_W]);
            end
        end
    end

endmodule

// File: rtl/vec_intc.sv
module vec_intc
    import vec_intc_pkg::*;
#(
    parameter int N_SRC    = 8,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 3,
    parameter int N_MASK   = 2,
    parameter int VEC_W    = 12,
    parameter int VEC_BASE = 'h200,
    parameter int VEC_STEP = 'h20,
    parameter logic [N_SRC*LVL_W-1:0] PRI_RST  = 32'hDA74_0000,
    parameter logic [N_MASK*N_SRC-1:0] MASK_RST = 16'hF0FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_waddr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [ADDR_W-1:0] reg_raddr,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_SRC-1:0]  irq_in,
    input  logic [LVL_W-1:0]  cpu_level,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec,
    output logic [LVL_W-1:0]  irq_level
);

    localparam int IDX_W = $clog2(N_SRC);
    localparam int PTOT  = N_SRC * LVL_W;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        logic [LVL_W-1:0] lvl;
    } gnt_t;

    gnt_t g_q, g_d;

    logic              lvl_mode;
    logic [PTOT-1:0]   prio_flat;
    logic [N_SRC-1:0]  mask_ok;
    logic [N_SRC-1:0]  pend_q;
    logic [N_SRC-1:0]  elig;
    logic              found;
    logic [IDX_W-1:0]  win_idx;
    logic [ARB_W-1:0]  win_arb;
    logic              take;
    logic [LVL_W-1:0]  held_field;
    logic              held_ok;

    vec_intc_regs #(
        .N_SRC    (N_SRC),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .N_MASK   (N_MASK),
        .PRI_RST  (PRI_RST),
        .MASK_RST (MASK_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .wr_addr   (reg_waddr),
        .wr_data   (reg_wdata),
        .rd_addr   (reg_raddr),
        .rd_data   (reg_rdata),
        .lvl_mode  (lvl_mode),
        .prio_flat (prio_flat),
        .mask_ok   (mask_ok)
    );

    vec_intc_pending #(
        .N_SRC (N_SRC)
    ) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (irq_in),
        .lvl_mode (lvl_mode),
        .clr_en   (take),
        .clr_idx  (g_q.idx),
        .pend     (pend_q)
    );

    vec_intc_arb #(
        .N_SRC (N_SRC)
    ) u_arb (
        .pend      (pend_q),
        .prio_flat (prio_flat),
        .mask_ok   (mask_ok),
        .elig      (elig),
        .found     (found),
        .win_idx   (win_idx),
        .win_arb   (win_arb)
    );

    always_comb begin
        take       = irq_ack & g_q.valid;
        held_field = prio_flat[PTOT-1-int'(g_q.idx)*LVL_W -: LVL_W];
        held_ok    = elig[g_q.idx] && (to_level(widen_prio(held_field)) > cpu_level);
        g_d        = g_q;
        if (take) begin
            g_d = '0;
        end else if (g_q.valid && held_ok) begin
            g_d = g_q;
        end else begin
            g_d.valid = found && (to_level(win_arb) > cpu_level);
            g_d.idx   = g_d.valid ? win_idx : '0;
            g_d.lvl   = g_d.valid ? to_level(win_arb) : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign irq_req   = g_q.valid;
    assign irq_level = g_q.lvl;
    assign irq_vec   = g_q.valid
                     ? VEC_W'(VEC_BASE) + VEC_W'(g_q.idx) * VEC_W'(VEC_STEP)
                     : '0;

endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk #(
    parameter int N_SRC    = 8,
    parameter int VEC_W    = 12,
    parameter int VEC_BASE = 'h200,
    parameter int VEC_STEP = 'h20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_req,
    input logic             irq_ack,
    input logic [VEC_W-1:0] irq_vec,
    input logic [3:0]       irq_level,
    input logic [3:0]       cpu_level,
    input logic [N_SRC-1:0] pend
);

    AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && irq_ack |=> !irq_req);                                   // R10

    AST_IDLE_OUTPUTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_vec == '0 && irq_level == '0));                   // R8

    AST_VEC_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (int'(irq_vec) >= VEC_BASE
                     && ((int'(irq_vec) - VEC_BASE) % VEC_STEP) == 0
                     && ((int'(irq_vec) - VEC_BASE) / VEC_STEP) < N_SRC));  // R8

    AST_NEW_GRANT_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> irq_level > $past(cpu_level));                   // R7

    AST_REQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(|pend));                                          // R9

    AST_LEVEL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> irq_level != '0);                                       // R3

endmodule

bind vec_intc vec_intc_chk #(
    .N_SRC    (N_SRC),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .irq_ack   (irq_ack),
    .irq_vec   (irq_vec),
    .irq_level (irq_level),
    .cpu_level (cpu_level),
    .pend      (pend_q)
);

// File: tb/vec_intc_tb.sv
`timescale 1ns/1ps
module vec_intc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_waddr = '0;
    logic [15:0] reg_wdata = '0;
    logic [2:0]  reg_raddr = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  irq_in = '0;
    logic [3:0]  cpu_level = '0;
    logic        irq_ack = 1'b0;
    logic        irq_req;
    logic [11:0] irq_vec;
    logic [3:0]  irq_level;

    int n_chk = 0;
    int n_fail = 0;
    bit checking = 0;
    bit done = 0;
    string phase = "R1";

    always #5 clk = ~clk;

    vec_intc u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .irq_in(irq_in), .cpu_level(cpu_level), .irq_ack(irq_ack),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_level(irq_level)
    );

    // ---------------- behavioural reference ----------------
    int m_ctrl;
    int m_pri[2];
    int m_mask[2];
    bit m_pend[8];
    bit m_prev[8];
    bit m_valid;
    int m_idx;
    int m_lvl;

    function automatic int fld(int s);
        return (m_pri[s / 4] >> (12 - 4 * (s % 4))) & 15;
    endfunction

    function automatic bit eligible(int s);
        return m_pend[s] && ((m_mask[0] >> (7 - s)) & 1) == 1
            && ((m_mask[1] >> (7 - s)) & 1) == 1 && fld(s) != 0;
    endfunction

    function automatic int exp_rd(int a);
        case (a)
            0: return m_ctrl & 1;
            1: return m_pri[0];
            2: return m_pri[1];
            3: return m_mask[0];
            4: return m_mask[1];
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        bit take;
        bit nv;
        int ni;
        int nl;
        int best;
        int bp;
        if (!rst_n) begin
            m_ctrl = 0; m_pri[0] = 'hDA74; m_pri[1] = 0;
            m_mask[0] = 'hF0; m_mask[1] = 'hFF;
            for (int i = 0; i < 8; i++) begin m_pend[i] = 0; m_prev[i] = 0; end
            m_valid = 0; m_idx = 0; m_lvl = 0;
        end else begin
            take = irq_ack && m_valid;
            nv = m_valid; ni = m_idx; nl = m_lvl;
            if (take) begin
                nv = 0; ni = 0; nl = 0;
            end else if (!(m_valid && eligible(m_idx) && fld(m_idx) > int'(cpu_level))) begin
                best = -1; bp = 0;
                for (int i = 0; i < 8; i++)
                    if (eligible(i) && (best < 0 || fld(i) > bp)) begin best = i; bp = fld(i); end
                nv = (best >= 0) && bp > int'(cpu_level);
                ni = nv ? best : 0;
                nl = nv ? bp : 0;
            end
            for (int i = 0; i < 8; i++) begin
                if (m_ctrl & 1)
                    m_pend[i] = irq_in[i] && !(take && i == m_idx);
                else
                    m_pend[i] = (m_pend[i] || (irq_in[i] && !m_prev[i])) && !(take && i == m_idx);
                m_prev[i] = irq_in[i];
            end
            if (reg_wr) begin
                case (int'(reg_waddr))
                    0: m_ctrl = reg_wdata & 1;
                    1: m_pri[0] = reg_wdata;
                    2: m_pri[1] = reg_wdata;
                    3: m_mask[0] = reg_wdata & 'hFF;
                    4: m_mask[1] = reg_wdata & 'hFF;
                    default: ;
                endcase
            end
            m_valid = nv; m_idx = ni; m_lvl = nl;
        end
    end

    task automatic chk(string tag, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Cycle compare against the model, 1 ns after the falling edge.
    always begin
        @(negedge clk);
        #1;
        if (checking && rst_n) begin
            chk(phase, int'(irq_req), int'(m_valid), "irq_req");
            chk(phase, int'(irq_vec), m_valid ? ('h200 + m_idx * 'h20) : 0, "irq_vec");
            chk(phase, int'(irq_level), m_lvl, "irq_level");
            chk(phase, int'(reg_rdata), exp_rd(int'(reg_raddr)), "reg_rdata");
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int a, int d);
        reg_wr = 1; reg_waddr = 3'(a); reg_wdata = 16'(d);
        tick();
        reg_wr = 0;
    endtask

    task automatic pulse(int s);
        irq_in[s] = 1; tick(); irq_in[s] = 0;
    endtask

    task automatic ack();
        irq_ack = 1; tick(); irq_ack = 0;
    endtask

    // Direct check 2 ns after the current falling edge.
    task automatic see(string tag, int req, int vec, int lvl);
        #2;
        chk(tag, int'(irq_req), req, "irq_req");
        if (req != 0) begin
            chk(tag, int'(irq_vec), vec, "irq_vec");
            chk(tag, int'(irq_level), lvl, "irq_level");
        end
    endtask

    task automatic rd_chk(string tag, int a, int exp);
        reg_raddr = 3'(a);
        #2;
        chk(tag, int'(reg_rdata), exp, "reg_rdata");
    endtask

    initial begin
        tick(3);
        rst_n = 1;
        checking = 1;
        tick();

        // R1: reset values
        phase = "R1";
        see("R1", 0, 0, 0);
        rd_chk("R1", 0, 0);
        rd_chk("R1", 1, 'hDA74);
        rd_chk("R1", 2, 0);
        rd_chk("R1", 3, 'hF0);
        rd_chk("R1", 4, 'hFF);
        tick();

        // R12: write timing, unmapped space
        phase = "R12";
        reg_raddr = 2;
        wr(2, 'h1234);
        rd_chk("R12", 2, 'h1234);
        wr(6, 'hBEEF);
        rd_chk("R12", 6, 0);
        rd_chk("R12", 2, 'h1234);
        wr(3, 'hFF);
        tick();

        // R4 / R9: edge capture and two-clock latency
        phase = "R4";
        irq_in[2] = 1; tick(); irq_in[2] = 0;
        see("R9", 0, 0, 0);
        tick();
        see("R4", 1, 'h240, 7);
        tick(2);
        see("R4", 1, 'h240, 7);
        phase = "R10";
        ack();
        see("R10", 0, 0, 0);
        tick(2);

        // R7: strict level comparison
        phase = "R7";
        cpu_level = 7;
        pulse(2);
        tick(3);
        see("R7", 0, 0, 0);
        cpu_level = 6;
        tick(2);
        see("R7", 1, 'h240, 7);
        ack();
        cpu_level = 0;
        tick(2);

        // R2: nibble packing, boundary level 15
        phase = "R2";
        wr(1, 'h0F00);
        cpu_level = 14;
        pulse(1);
        tick();
        see("R2", 1, 'h220, 15);
        ack();
        cpu_level = 15;
        pulse(1);
        tick(3);
        see("R7", 0, 0, 0);
        cpu_level = 0;
        tick(2);
        see("R2", 1, 'h220, 15);
        ack();
        tick(2);

        // R6: tie goes to lower index
        phase = "R6";
        wr(2, 'h5555);
        irq_in[5] = 1; irq_in[6] = 1; tick(); irq_in = '0;
        tick();
        see("R6", 1, 'h2A0, 5);
        ack();
        tick();
        see("R6", 1, 'h2C0, 5);
        ack();
        tick(2);

        // R3: mask and zero-priority gating
        phase = "R3";
        wr(1, 'hDA74);
        wr(4, 'h7F);
        pulse(0);
        tick(3);
        see("R3", 0, 0, 0);
        wr(1, 'hD074);
        pulse(1);
        tick(3);
        see("R3", 0, 0, 0);
        wr(4, 'hFF);
        tick();
        see("R3", 1, 'h200, 13);
        ack();
        tick(2);
        wr(1, 'hDA74);
        tick(2);
        see("R3", 1, 'h220, 10);
        ack();
        tick(2);

        // R11: hold against a more urgent arrival
        phase = "R11";
        pulse(3);
        tick();
        see("R11", 1, 'h260, 4);
        pulse(0);
        tick(3);
        see("R11", 1, 'h260, 4);
        wr(3, 'hEF);
        tick();
        see("R11", 1, 'h200, 13);
        wr(3, 'hFF);
        ack();
        tick();
        see("R11", 1, 'h260, 4);
        ack();
        tick(2);

        // R10: acknowledge while idle
        phase = "R10";
        irq_ack = 1; tick(3); irq_ack = 0;
        see("R10", 0, 0, 0);
        pulse(2);
        tick();
        see("R10", 1, 'h240, 7);
        ack();
        tick(2);

        // R5: level-following mode
        phase = "R5";
        wr(0, 1);
        reg_raddr = 0;
        irq_in[2] = 1;
        tick(2);
        see("R5", 1, 'h240, 7);
        irq_in[2] = 0;
        tick(2);
        see("R5", 0, 0, 0);
        irq_in[2] = 1;
        tick(2);
        see("R5", 1, 'h240, 7);
        ack();
        see("R5", 0, 0, 0);
        tick(2);
        see("R5", 1, 'h240, 7);
        irq_in = '0;
        tick(3);

        // R8: randomised mix against the model
        phase = "R8";
        for (int c = 0; c < 3000; c++) begin
            irq_in = 8'($urandom) & 8'($urandom);
            if ($urandom % 8 == 0) cpu_level = 4'($urandom % 10);
            reg_raddr = 3'($urandom);
            irq_ack = irq_req && ($urandom % 3 == 0);
            if ($urandom % 12 == 0) begin
                reg_wr = 1;
                reg_waddr = 3'($urandom);
                reg_wdata = 16'($urandom);
                if (reg_waddr == 3 || reg_waddr == 4) reg_wdata = reg_wdata | 16'h00C3;
            end else begin
                reg_wr = 0;
            end
            tick();
        end
        reg_wr = 0; irq_ack = 0; irq_in = '0;
        tick(3);
        finish_run();
    end

endmodule